// File: doc/BRIEF.md
# Dual-Standard FSK Tone Modulator

This block synthesizes the transmit carrier of a 300-baud frequency-shift-keyed modem as a stream of signed sine samples. It serves either of two common low-speed frequency plans: the North American 300-baud plan or the international 300-baud plan. The master clock is 3.579545 MHz. An internal divider makes a sample strobe once every 46 master clocks, about 77.82 kHz. At each strobe a phase accumulator advances by a frequency-dependent step. The upper phase bits address a quarter-wave sine table, and table symmetry rebuilds the full wave.

A single control decode turns the data bit, the plan select, the calling/called side select, the mute input and a three-level test control into several results: the transmit step, the pair of receive steps handed to a companion demodulator, a mute condition and a sleep flag. The test control can replace the data tones with a fixed echo-suppression tone, or make the receive pair equal to the transmit pair for a local self test. A change of frequency never restarts the phase, so the output wave stays continuous.

Top module: `fsk_tone_mod`

## Requirements
- R1: With `std_v21_i`=0, `mode_orig_i`=1 selects transmit space 1070 Hz and mark 1270 Hz. `mode_orig_i`=0 selects transmit space 2025 Hz and mark 2225 Hz. `tx_data_i`=1 selects mark and `tx_data_i`=0 selects space. A frequency f is applied as the phase step round(f·2^24·46/3579545).
- R2: With `std_v21_i`=1, `mode_orig_i`=1 selects transmit space 1180 Hz and mark 980 Hz. `mode_orig_i`=0 selects space 1850 Hz and mark 1650 Hz.
- R3: With `squelch_i`=0 and `loop_i`=2'b01 (mid), the transmit step is a fixed echo tone regardless of data: 2225 Hz when `std_v21_i`=0, 2100 Hz when `std_v21_i`=1.
- R4: Outside self test, the receive steps (`rx_space_inc_o`, `rx_mark_inc_o`) are the other side's transmit pair. For `std_v21_i`=0 that is 2025/2225 Hz when originating and 1070/1270 Hz when answering. For `std_v21_i`=1 it is 1850/1650 Hz on the mode-high side and 1180/980 Hz on the mode-low side. These outputs are registered one cycle after the inputs.
- R5: With `squelch_i`=0 and `loop_i`=2'b10 (high), the receive steps equal the transmit space and mark steps of the selected plan and side.
- R6: With `squelch_i`=1, each strobe clears the phase accumulator and yields a sample of 0, and `valid_o` keeps pulsing.
- R7: With `squelch_i`=1 and `loop_i`=2'b10, `pdown_o` is 1 one cycle later and no `valid_o` pulse appears. Otherwise `pdown_o` is 0.
- R8: Unless powered down, `valid_o` is a one-cycle pulse every 46 clocks. The first pulse comes 47 rising edges after reset is released.
- R9: At each unmuted strobe the 24-bit phase advances by the current step modulo 2^24. It is never reset by a change of step, so data toggles stay phase continuous.
- R10: The sample for a strobe is the phase before that strobe's advance. Let p be the top 8 bits of that phase. The sample is round(32767·sin(2π(p+0.5)/256)). It appears on `sample_o` with `valid_o`, two edges after the strobe edge, and is held between pulses.
- R11: After reset, `sample_o`=0, `valid_o`=0, `pdown_o`=0 and the phase is 0.
- R12: The code `loop_i`=2'b11 behaves as 2'b00 (normal operation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data_i | input | 1 | Transmit bit: 1 mark, 0 space |
| std_v21_i | input | 1 | Frequency plan: 0 North American, 1 international |
| mode_orig_i | input | 1 | 1 originate / channel 1, 0 answer / channel 2 |
| squelch_i | input | 1 | Mutes the modulator |
| loop_i | input | 2 | Test control: 00 low, 01 mid (echo tone), 10 high (self test) |
| sample_o | output | 16 | Signed sine sample |
| valid_o | output | 1 | One-cycle pulse marking a new sample |
| rx_space_inc_o | output | 24 | Phase step of the receive space tone |
| rx_mark_inc_o | output | 24 | Phase step of the receive mark tone |
| pdown_o | output | 1 | Power-down indication |

## Verification
A strobe is internal and falls on the 46th clock of each divider period. Its sample appears two rising edges later, when `valid_o` rises. `rx_space_inc_o`, `rx_mark_inc_o` and `pdown_o` show the control decode one edge after the inputs settle. The bench steps a behavioural model at every rising edge that applies these same delays: it keeps an integer phase and a two-slot sample pipe. The bench changes inputs just after an edge and compares every output at the falling edge, so each result is checked in the cycle it becomes due. A separate measurement of the spacing between pulses confirms the 46-clock sample period.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

  typedef enum logic [1:0] {
    LOOP_LO  = 2'b00,
    LOOP_MID = 2'b01,
    LOOP_HI  = 2'b10,
    LOOP_RSV = 2'b11
  } loop_e;

  localparam int unsigned MCLK_HZ_DEF = 3579545;

  // tone frequencies in Hz
  localparam int unsigned F_NA_LO_S  = 1070;
  localparam int unsigned F_NA_LO_M  = 1270;
  localparam int unsigned F_NA_HI_S  = 2025;
  localparam int unsigned F_NA_HI_M  = 2225;
  localparam int unsigned F_IN_C1_S  = 1180;
  localparam int unsigned F_IN_C1_M  = 980;
  localparam int unsigned F_IN_C2_S  = 1850;
  localparam int unsigned F_IN_C2_M  = 1650;
  localparam int unsigned F_ECHO_NA  = 2225;
  localparam int unsigned F_ECHO_IN  = 2100;

  // rounded phase step for frequency f with a pw-bit accumulator
  function automatic longint unsigned step_for(input int unsigned f,
                                               input int unsigned pw,
                                               input int unsigned div,
                                               input int unsigned mclk);
    longint unsigned num;
    num = ((longint'(f) << pw) * longint'(div)) + longint'(mclk / 2);
    return num / longint'(mclk);
  endfunction

endpackage

// File: rtl/fsk_strobe_gen.sv
module fsk_strobe_gen #(
  parameter int unsigned DIV = 46
) (
  input  logic clk,
  input  logic rst,
  output logic strobe_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign strobe_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (strobe_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsk_tone_plan.sv
module fsk_tone_plan
  import fsk_tone_pkg::*;
#(
  parameter int unsigned PHASE_W = 24,
  parameter int unsigned DIV     = 46,
  parameter int unsigned MCLK_HZ = MCLK_HZ_DEF
) (
  input  logic               tx_data_i,
  input  logic               std_v21_i,
  input  logic               mode_orig_i,
  input  logic               squelch_i,
  input  logic [1:0]         loop_i,
  output logic [PHASE_W-1:0] tx_inc_o,
  output logic [PHASE_W-1:0] rx_space_o,
  output logic [PHASE_W-1:0] rx_mark_o,
  output logic               mute_o,
  output logic               pdown_o
);
  localparam logic [PHASE_W-1:0] S_NA_LO_S = PHASE_W'(step_for(F_NA_LO_S, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_NA_LO_M = PHASE_W'(step_for(F_NA_LO_M, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_NA_HI_S = PHASE_W'(step_for(F_NA_HI_S, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_NA_HI_M = PHASE_W'(step_for(F_NA_HI_M, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_IN_C1_S = PHASE_W'(step_for(F_IN_C1_S, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_IN_C1_M = PHASE_W'(step_for(F_IN_C1_M, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_IN_C2_S = PHASE_W'(step_for(F_IN_C2_S, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_IN_C2_M = PHASE_W'(step_for(F_IN_C2_M, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_ECHO_NA = PHASE_W'(step_for(F_ECHO_NA, PHASE_W, DIV, MCLK_HZ));
  localparam logic [PHASE_W-1:0] S_ECHO_IN = PHASE_W'(step_for(F_ECHO_IN, PHASE_W, DIV, MCLK_HZ));

  loop_e loop_sel;
  logic  echo_on, self_test;
  logic [PHASE_W-1:0] tx_s, tx_m, far_s, far_m, echo_inc;

  assign loop_sel  = loop_e'(loop_i);
  assign echo_on   = !squelch_i && (loop_sel == LOOP_MID);
  assign self_test = !squelch_i && (loop_sel == LOOP_HI);
  assign mute_o    = squelch_i;
  assign pdown_o   = squelch_i && (loop_sel == LOOP_HI);

  always_comb begin
    if (std_v21_i) begin
      echo_inc = S_ECHO_IN;
      if (mode_orig_i) begin
        tx_s = S_IN_C1_S; tx_m = S_IN_C1_M;
        far_s = S_IN_C2_S; far_m = S_IN_C2_M;
      end else begin
        tx_s = S_IN_C2_S; tx_m = S_IN_C2_M;
        far_s = S_IN_C1_S; far_m = S_IN_C1_M;
      end
    end else begin
      echo_inc = S_ECHO_NA;
      if (mode_orig_i) begin
        tx_s = S_NA_LO_S; tx_m = S_NA_LO_M;
        far_s = S_NA_HI_S; far_m = S_NA_HI_M;
      end else begin
        tx_s = S_NA_HI_S; tx_m = S_NA_HI_M;
        far_s = S_NA_LO_S; far_m = S_NA_LO_M;
      end
    end
  end

  always_comb begin
    if (echo_on)        tx_inc_o = echo_inc;
    else if (tx_data_i) tx_inc_o = tx_m;
    else                tx_inc_o = tx_s;
    rx_space_o = self_test ? tx_s : far_s;
    rx_mark_o  = self_test ? tx_m : far_m;
  end
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int unsigned PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  input  logic               clear,
  input  logic [PHASE_W-1:0] inc,
  output logic [PHASE_W-1:0] phase_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= '0;
    end else if (step_en) begin
      if (clear) phase_o <= '0;
      else       phase_o <= phase_o + inc;
    end
  end
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
  parameter int unsigned PHASE_W = 24,
  parameter int unsigned LUT_AW  = 6,
  parameter int unsigned SAMP_W  = 16
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [PHASE_W-1:0] phase,
  output logic [SAMP_W-2:0] mag_o,
  output logic              neg_o
);
  localparam int unsigned DEPTH = 1 << LUT_AW;
  localparam real         AMP   = real'((1 << (SAMP_W - 1)) - 1);
  localparam real         HALF_PI = 1.5707963267948966;

  logic [SAMP_W-2:0] rom [0:DEPTH-1];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      rom[k] = (SAMP_W-1)'($rtoi(AMP * $sin(HALF_PI * (real'(k) + 0.5) / real'(DEPTH)) + 0.5));
    end
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] addr, idx;

  assign quad = phase[PHASE_W-1 -: 2];
  assign addr = phase[PHASE_W-3 -: LUT_AW];
  assign idx  = quad[0] ? ~addr : addr;

  always_ff @(posedge clk) begin
    if (rd_en) begin
      mag_o <= rom[idx];
      neg_o <= quad[1];
    end
  end
endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
  import fsk_tone_pkg::*;
#(
  parameter int unsigned PHASE_W = 24,
  parameter int unsigned LUT_AW  = 6,
  parameter int unsigned SAMP_W  = 16,
  parameter int unsigned DIV     = 46,
  parameter int unsigned MCLK_HZ = MCLK_HZ_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_data_i,
  input  logic                     std_v21_i,
  input  logic                     mode_orig_i,
  input  logic                     squelch_i,
  input  logic [1:0]               loop_i,
  output logic signed [SAMP_W-1:0] sample_o,
  output logic                     valid_o,
  output logic [PHASE_W-1:0]       rx_space_inc_o,
  output logic [PHASE_W-1:0]       rx_mark_inc_o,
  output logic                     pdown_o
);
  logic               strobe, mute, pdown;
  logic [PHASE_W-1:0] tx_inc, rx_s, rx_m, phase_q;
  logic [SAMP_W-2:0]  mag;
  logic               neg;
  logic               v1_q, mute1_q, pd1_q;
  logic signed [SAMP_W-1:0] signed_mag;

  fsk_strobe_gen #(.DIV(DIV)) u_strobe (
    .clk(clk), .rst(rst), .strobe_o(strobe)
  );

  fsk_tone_plan #(.PHASE_W(PHASE_W), .DIV(DIV), .MCLK_HZ(MCLK_HZ)) u_plan (
    .tx_data_i(tx_data_i), .std_v21_i(std_v21_i), .mode_orig_i(mode_orig_i),
    .squelch_i(squelch_i), .loop_i(loop_i),
    .tx_inc_o(tx_inc), .rx_space_o(rx_s), .rx_mark_o(rx_m),
    .mute_o(mute), .pdown_o(pdown)
  );

  fsk_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .step_en(strobe), .clear(mute),
    .inc(tx_inc), .phase_o(phase_q)
  );

  fsk_sine_rom #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_rom (
    .clk(clk), .rd_en(strobe), .phase(phase_q), .mag_o(mag), .neg_o(neg)
  );

  assign signed_mag = $signed({1'b0, mag});

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q    <= 1'b0;
      mute1_q <= 1'b0;
      pd1_q   <= 1'b0;
    end else begin
      v1_q <= strobe;
      if (strobe) begin
        mute1_q <= mute;
        pd1_q   <= pdown;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else if (v1_q) begin
      valid_o  <= !pd1_q;
      sample_o <= mute1_q ? '0 : (neg ? -signed_mag : signed_mag);
    end else begin
      valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_space_inc_o <= '0;
      rx_mark_inc_o  <= '0;
      pdown_o        <= 1'b0;
    end else begin
      rx_space_inc_o <= rx_s;
      rx_mark_inc_o  <= rx_m;
      pdown_o        <= pdown;
    end
  end
endmodule

// File: rtl/fsk_tone_mod_sva.sv
module fsk_tone_mod_sva #(
  parameter int unsigned PHASE_W = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               strobe,
  input logic               mute,
  input logic [PHASE_W-1:0] phase_q,
  input logic [PHASE_W-1:0] inc,
  input logic               valid_o,
  input logic               pdown_o
);
  // R9: unmuted strobe advances the phase by the step in force
  assert_phase_step_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe && !mute) |=> (phase_q == $past(phase_q + inc)));

  // R6: muted strobe leaves the accumulator at zero
  assert_mute_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe && mute) |=> (phase_q == '0));

  // R8: valid is a single-cycle pulse
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R10: each sample is due two edges after its strobe
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(strobe, 2));

  // R7: no sample while powered down
  assert_pdown_silent_R7: assert property (@(posedge clk) disable iff (rst)
    $past(pdown_o) |-> !valid_o);
endmodule

bind fsk_tone_mod fsk_tone_mod_sva #(.PHASE_W(PHASE_W)) u_sva (
  .clk(clk), .rst(rst), .strobe(strobe), .mute(mute), .phase_q(phase_q),
  .inc(tx_inc), .valid_o(valid_o), .pdown_o(pdown_o)
);

// File: tb/fsk_tone_mod_test.sv
`timescale 1ns/1ps
module fsk_tone_mod_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_data = 1'b0, std_v21 = 1'b0, mode_orig = 1'b1, squelch = 1'b0;
  logic [1:0] loop_c = 2'b00;
  logic signed [15:0] sample;
  logic valid, pdown;
  logic [23:0] rx_s, rx_m;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";
  longint cyc = 0;
  longint last_valid = -1;

  always #5 clk = ~clk;

  fsk_tone_mod uut (
    .clk(clk), .rst(rst), .tx_data_i(tx_data), .std_v21_i(std_v21),
    .mode_orig_i(mode_orig), .squelch_i(squelch), .loop_i(loop_c),
    .sample_o(sample), .valid_o(valid), .rx_space_inc_o(rx_s),
    .rx_mark_inc_o(rx_m), .pdown_o(pdown)
  );

  function automatic longint step_of(int f);
    return ((longint'(f) * 64'd16777216 * 46) + 3579545 / 2) / 3579545;
  endfunction

  function automatic int sine_of(longint ph);
    longint p;
    real v;
    p = ph >> 16;
    v = 32767.0 * $sin(6.283185307179586 * (real'(p) + 0.5) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  // reference model state
  int     divc = 0;
  longint ph = 0;
  bit     s1_v = 0, s1_m = 0, s1_p = 0;
  int     s1_val = 0;
  bit     e_valid = 0, e_pd = 0;
  int     e_sample = 0;
  longint e_rxs = 0, e_rxm = 0;

  always @(posedge clk) begin
    bit strobe_m, mute_m, pd_m, echo_m, self_m;
    int ts, tm, fs, fm, tf;
    cyc++;
    if (rst) begin
      divc = 0; ph = 0; s1_v = 0; s1_m = 0; s1_p = 0; s1_val = 0;
      e_valid = 0; e_pd = 0; e_sample = 0; e_rxs = 0; e_rxm = 0;
    end else begin
      strobe_m = (divc == 45);
      divc = strobe_m ? 0 : divc + 1;
      if (!std_v21) begin
        if (mode_orig) begin ts = 1070; tm = 1270; fs = 2025; fm = 2225; end
        else           begin ts = 2025; tm = 2225; fs = 1070; fm = 1270; end
      end else begin
        if (mode_orig) begin ts = 1180; tm = 980;  fs = 1850; fm = 1650; end
        else           begin ts = 1850; tm = 1650; fs = 1180; fm = 980;  end
      end
      echo_m = !squelch && loop_c == 2'b01;
      self_m = !squelch && loop_c == 2'b10;
      mute_m = squelch;
      pd_m   = squelch && loop_c == 2'b10;
      tf = echo_m ? (std_v21 ? 2100 : 2225) : (tx_data ? tm : ts);
      if (s1_v) begin
        e_valid = !s1_p;
        e_sample = s1_m ? 0 : s1_val;
      end else e_valid = 0;
      s1_v = strobe_m;
      if (strobe_m) begin
        s1_m = mute_m; s1_p = pd_m; s1_val = sine_of(ph);
        ph = mute_m ? 0 : ((ph + step_of(tf)) & 64'hFFFFFF);
      end
      e_pd = pd_m;
      e_rxs = step_of(self_m ? ts : fs);
      e_rxm = step_of(self_m ? tm : fm);
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(cur_req, "valid", valid, e_valid);
    chk(cur_req, "sample", sample, e_sample);
    chk(cur_req, "pdown", pdown, e_pd);
    chk(cur_req, "rx_space", rx_s, e_rxs);
    chk(cur_req, "rx_mark", rx_m, e_rxm);
    if (rst || pdown) last_valid = -1;
    else if (valid) begin
      if (last_valid >= 0) chk("R8", "valid spacing", cyc - last_valid, 46);
      last_valid = cyc;
    end
  end

  task automatic seg(string req, bit d, bit sv, bit mo, bit sq, bit [1:0] lp, int n);
    cur_req = req;
    tx_data = d; std_v21 = sv; mode_orig = mo; squelch = sq; loop_c = lp;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #200_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    cur_req = "R11";
    repeat (60) @(posedge clk);
    #1;
    seg("R1", 1, 0, 1, 0, 2'b00, 700);
    seg("R1", 0, 0, 1, 0, 2'b00, 700);
    seg("R4", 1, 0, 0, 0, 2'b00, 700);
    seg("R2", 1, 1, 1, 0, 2'b00, 700);
    seg("R2", 0, 1, 0, 0, 2'b00, 700);
    seg("R3", 1, 0, 1, 0, 2'b01, 700);
    seg("R3", 0, 1, 0, 0, 2'b01, 700);
    seg("R5", 1, 0, 1, 0, 2'b10, 300);
    seg("R5", 0, 1, 0, 0, 2'b10, 300);
    seg("R12", 1, 1, 1, 0, 2'b11, 500);
    seg("R6", 1, 0, 1, 1, 2'b00, 400);
    seg("R7", 1, 0, 1, 1, 2'b10, 400);
    seg("R10", 0, 1, 1, 0, 2'b00, 600);
    for (int i = 0; i < 40; i++) begin
      seg("R9", i[0], 0, i[2], 0, 2'b00, 23 + (i % 7));
    end
    seg("R6", 0, 1, 1, 1, 2'b01, 200);
    seg("R10", 1, 1, 0, 0, 2'b00, 600);
    rst = 1'b1;
    cur_req = "R11";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (50) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule